// File: doc/BRIEF.md
# Rename History Log with Squash Rollback and Commit Release

This block keeps an ordered record of the register renames made by one thread's rename stage. Each time a destination register gets a fresh physical register, the stage appends a record holding the instruction sequence number, the architectural register, the newly granted physical register and the physical register it replaces. The record is a circular array that is emptied from either end.

On a squash, records are removed from the young end, one per cycle. Each removal writes the previous mapping back into the rename map and returns the new physical register to the free list. A flush-all request removes every record in the same way. On a commit, records are removed from the old end. Each removal returns the superseded physical register to the free list. Two counters record how many mappings were undone and how many were committed.

A four-state-free controller runs the walks with three named states. `WALK_IDLE` accepts appends and requests. `WALK_UNDO` removes young records. `WALK_RELEASE` removes old records. The transitions are: IDLE→UNDO on a flush or squash request; IDLE→RELEASE on an accepted commit; UNDO→IDLE when the youngest record is not younger than the target, or the log is empty; RELEASE→IDLE when the oldest record is newer than the target, or the log is empty.

Top module: `rename_history_log`

## Requirements
- R1: After reset the log is empty: `busy`, `full`, `restore_valid` and `free_valid` are low, and both counters read zero.
- R2: An append is stored only when `app_valid` is high, the log holds fewer than DEPTH (32) records, `busy` is low and neither `squash_valid` nor `flush_valid` is high. `full` is high while 32 records are held, and appends then have no effect.
- R3: A squash with number S starts the cycle after the request. Each cycle it removes the youngest record while that record's sequence number is greater than S (unsigned compare). The removal shows `restore_valid` with `restore_arch` and `restore_phys` set to the record's architectural and previous physical register, and `free_valid` with `free_phys` set to the record's new physical register.
- R4: A flush-all request removes every record, youngest first, with the same outputs as in R3.
- R5: A commit with a non-zero number C removes the oldest record each cycle while its sequence number is at most C. The removal shows `free_valid` with `free_phys` set to the record's previous physical register, and `restore_valid` low.
- R6: A commit is ignored when C is zero, when the log is empty, or when the oldest record's sequence number is greater than C. `busy` stays low and no record is freed.
- R7: `busy` is high from the cycle after an accepted request until the cycle after the last removal, inclusive. Requests that arrive while `busy` is high are ignored. In one idle cycle, flush takes priority over squash, and squash over commit. A commit that arrives in the same cycle as a squash or flush is dropped.
- R8: `undone_cnt` rises by one for each record removed by a squash or flush. `committed_cnt` rises by one for each record removed by a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_valid | input | 1 | Append a record this cycle |
| app_seq | input | SEQ_W | Sequence number of the renaming instruction |
| app_arch | input | ARCH_W | Architectural destination register |
| app_new_phys | input | PHYS_W | Newly granted physical register |
| app_prev_phys | input | PHYS_W | Physical register previously mapped |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash number S; records younger than S are undone |
| flush_valid | input | 1 | Undo every record |
| commit_seq | input | SEQ_W | Commit number C; zero means no commit |
| restore_valid | output | 1 | Write the restored mapping into the rename map |
| restore_arch | output | ARCH_W | Architectural register to restore |
| restore_phys | output | PHYS_W | Physical register to map it back to |
| free_valid | output | 1 | Return a physical register to the free list |
| free_phys | output | PHYS_W | Physical register returned |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | Log holds DEPTH records |
| undone_cnt | output | CNT_W | Mappings undone so far |
| committed_cnt | output | CNT_W | Mappings committed so far |

## Verification
A request raised in one cycle is taken at the next edge. The first removal shows on the outputs in the cycle that follows that edge, and each later removal comes one cycle after the one before. After n removals there is one more busy cycle, and then `busy` drops. The bench raises a request for exactly one cycle. It then checks each removal at the falling edge of its own cycle against a model list, youngest or oldest first. It checks the one trailing busy cycle, then the idle cycle. Counter values are checked after the walk has ended. The bench checks that a stored append or an ignored request took effect, or did not, by walking the log afterwards and counting the removals.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE    = 2'd0,
        WALK_UNDO    = 2'd1,
        WALK_RELEASE = 2'd2
    } walk_state_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
    parameter int DEPTH  = 32,
    parameter int SEQ_W  = 16,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 7,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int FILL_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [ARCH_W-1:0] push_arch,
    input  logic [PHYS_W-1:0] push_new,
    input  logic [PHYS_W-1:0] push_prev,
    input  logic              pop_old,
    input  logic              pop_young,
    output logic [SEQ_W-1:0]  old_seq,
    output logic [PHYS_W-1:0] old_prev,
    output logic [SEQ_W-1:0]  young_seq,
    output logic [ARCH_W-1:0] young_arch,
    output logic [PHYS_W-1:0] young_new,
    output logic [PHYS_W-1:0] young_prev,
    output logic [FILL_W-1:0] fill,
    output logic              empty,
    output logic              full
);
    localparam logic [PTR_W-1:0]  LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] CAP      = FILL_W'(DEPTH);

    logic [SEQ_W-1:0]  seq_mem  [DEPTH];
    logic [ARCH_W-1:0] arch_mem [DEPTH];
    logic [PHYS_W-1:0] new_mem  [DEPTH];
    logic [PHYS_W-1:0] prev_mem [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q, young_idx;

    assign young_idx = (tail_q == '0) ? LAST_IDX : tail_q - 1'b1;
    assign empty     = (fill == '0);
    assign full      = (fill == CAP);

    assign old_seq    = seq_mem[head_q];
    assign old_prev   = prev_mem[head_q];
    assign young_seq  = seq_mem[young_idx];
    assign young_arch = arch_mem[young_idx];
    assign young_new  = new_mem[young_idx];
    assign young_prev = prev_mem[young_idx];

    always_ff @(posedge clk) begin
        if (push) begin
            seq_mem[tail_q]  <= push_seq;
            arch_mem[tail_q] <= push_arch;
            new_mem[tail_q]  <= push_new;
            prev_mem[tail_q] <= push_prev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            fill   <= '0;
        end else begin
            if (push && !pop_young)
                tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
            else if (pop_young && !push)
                tail_q <= young_idx;
            if (pop_old)
                head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
            fill <= fill + FILL_W'(push) - FILL_W'(pop_old) - FILL_W'(pop_young);
        end
    end
endmodule

// File: rtl/rhb_walk_ctrl.sv
module rhb_walk_ctrl
    import rhb_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             app_req,
    input  logic             squash_req,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             flush_req,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             empty,
    input  logic             full,
    input  logic [SEQ_W-1:0] old_seq,
    input  logic [SEQ_W-1:0] young_seq,
    output logic             push,
    output logic             pop_old,
    output logic             pop_young,
    output logic             busy
);
    walk_state_e      state_q, state_d;
    logic [SEQ_W-1:0] target_q, target_d;
    logic             all_q, all_d;

    logic commit_ok, undo_hit, release_hit;

    assign commit_ok   = (commit_seq != '0) && !empty && (old_seq <= commit_seq);
    assign undo_hit    = !empty && (all_q || (young_seq > target_q));
    assign release_hit = !empty && (old_seq <= target_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WALK_IDLE;
            target_q <= '0;
            all_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
            all_q    <= all_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        target_d = target_q;
        all_d    = all_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (flush_req) begin
                    state_d = WALK_UNDO;
                    all_d   = 1'b1;
                end else if (squash_req) begin
                    state_d  = WALK_UNDO;
                    all_d    = 1'b0;
                    target_d = squash_seq;
                end else if (commit_ok) begin
                    state_d  = WALK_RELEASE;
                    all_d    = 1'b0;
                    target_d = commit_seq;
                end
            end
            WALK_UNDO:    if (!undo_hit)    state_d = WALK_IDLE;
            WALK_RELEASE: if (!release_hit) state_d = WALK_IDLE;
            default:      state_d = WALK_IDLE;
        endcase
    end

    always_comb begin
        push      = 1'b0;
        pop_old   = 1'b0;
        pop_young = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            WALK_IDLE: begin
                busy = 1'b0;
                push = app_req && !full && !squash_req && !flush_req;
            end
            WALK_UNDO:    pop_young = undo_hit;
            WALK_RELEASE: pop_old   = release_hit;
            default:      busy      = 1'b1;
        endcase
    end
endmodule

// File: rtl/rhb_tally.sv
module rhb_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (bump) value <= value + 1'b1;
    end
endmodule

// File: rtl/rename_history_log.sv
module rename_history_log #(
    parameter int DEPTH  = 32,
    parameter int SEQ_W  = 16,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 7,
    parameter int CNT_W  = 16,
    localparam int FILL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_valid,
    input  logic [SEQ_W-1:0]  app_seq,
    input  logic [ARCH_W-1:0] app_arch,
    input  logic [PHYS_W-1:0] app_new_phys,
    input  logic [PHYS_W-1:0] app_prev_phys,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              restore_valid,
    output logic [ARCH_W-1:0] restore_arch,
    output logic [PHYS_W-1:0] restore_phys,
    output logic              free_valid,
    output logic [PHYS_W-1:0] free_phys,
    output logic              busy,
    output logic              full,
    output logic [CNT_W-1:0]  undone_cnt,
    output logic [CNT_W-1:0]  committed_cnt
);
    logic              push, pop_old, pop_young, empty;
    logic [SEQ_W-1:0]  old_seq, young_seq;
    logic [PHYS_W-1:0] old_prev, young_new, young_prev;
    logic [ARCH_W-1:0] young_arch;
    logic [FILL_W-1:0] fill_lvl;

    rhb_store #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_seq(app_seq), .push_arch(app_arch),
        .push_new(app_new_phys), .push_prev(app_prev_phys),
        .pop_old(pop_old), .pop_young(pop_young),
        .old_seq(old_seq), .old_prev(old_prev),
        .young_seq(young_seq), .young_arch(young_arch),
        .young_new(young_new), .young_prev(young_prev),
        .fill(fill_lvl), .empty(empty), .full(full)
    );

    rhb_walk_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .app_req(app_valid), .squash_req(squash_valid), .squash_seq(squash_seq),
        .flush_req(flush_valid), .commit_seq(commit_seq),
        .empty(empty), .full(full), .old_seq(old_seq), .young_seq(young_seq),
        .push(push), .pop_old(pop_old), .pop_young(pop_young), .busy(busy)
    );

    logic [1:0]       bumps;
    logic [CNT_W-1:0] tallies [2];
    assign bumps = {pop_old, pop_young};

    for (genvar g = 0; g < 2; g++) begin : g_tally
        rhb_tally #(.CNT_W(CNT_W)) u_tally (
            .clk(clk), .rst_n(rst_n), .bump(bumps[g]), .value(tallies[g])
        );
    end

    assign undone_cnt    = tallies[0];
    assign committed_cnt = tallies[1];

    assign restore_valid = pop_young;
    assign restore_arch  = young_arch;
    assign restore_phys  = young_prev;
    assign free_valid    = pop_young | pop_old;
    assign free_phys     = pop_young ? young_new : old_prev;
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 16,
    parameter int FILL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              full,
    input logic              squash_valid,
    input logic              flush_valid,
    input logic              restore_valid,
    input logic              free_valid,
    input logic [FILL_W-1:0] fill_lvl,
    input logic [CNT_W-1:0]  undone_cnt,
    input logic [CNT_W-1:0]  committed_cnt
);
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> fill_lvl <= $past(fill_lvl));
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= FILL_W'(DEPTH));
    a_r3_squash_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !busy) |=> busy);
    a_r4_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !busy) |=> busy);
    a_r3_restore_frees: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> free_valid);
    a_r3_restore_drops_fill: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> fill_lvl == $past(fill_lvl) - 1'b1);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !free_valid);
    a_r8_undo_tally: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> undone_cnt == $past(undone_cnt) + 1'b1);
    a_r8_commit_tally: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && !restore_valid) |=> committed_cnt == $past(committed_cnt) + 1'b1);
endmodule

bind rename_history_log rhb_checker #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .FILL_W(FILL_W)
) u_rhb_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .full(full),
    .squash_valid(squash_valid), .flush_valid(flush_valid),
    .restore_valid(restore_valid), .free_valid(free_valid),
    .fill_lvl(fill_lvl), .undone_cnt(undone_cnt), .committed_cnt(committed_cnt)
);

// File: tb/tb_rename_history_log.sv
`timescale 1ns/1ps
module tb_rename_history_log;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        app_valid, squash_valid, flush_valid;
    logic [15:0] app_seq, squash_seq, commit_seq;
    logic [4:0]  app_arch;
    logic [6:0]  app_new_phys, app_prev_phys;
    logic        restore_valid, free_valid, busy, full;
    logic [4:0]  restore_arch;
    logic [6:0]  restore_phys, free_phys;
    logic [15:0] undone_cnt, committed_cnt;

    always #2.5 clk = ~clk;

    rename_history_log dut (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int m_seq [64], m_arch [64], m_new [64], m_prev [64];
    int m_n = 0, next_seq = 10, exp_u = 0, exp_c = 0;

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic append(int arch, int np, int pp);
        @(negedge clk);
        app_valid = 1; app_seq = 16'(next_seq); app_arch = 5'(arch);
        app_new_phys = 7'(np); app_prev_phys = 7'(pp);
        if (m_n < 32) begin
            m_seq[m_n] = next_seq; m_arch[m_n] = arch;
            m_new[m_n] = np; m_prev[m_n] = pp; m_n++;
        end
        next_seq += 2;
        @(negedge clk);
        app_valid = 0;
    endtask

    task automatic request(bit sq, int s, bit fl, int c);
        @(negedge clk);
        squash_valid = sq; squash_seq = 16'(s); flush_valid = fl; commit_seq = 16'(c);
        @(negedge clk);
        squash_valid = 0; flush_valid = 0; commit_seq = 0;
    endtask

    function automatic int undo_count(int s, bit all);
        int k = 0;
        for (int i = m_n - 1; i >= 0; i--) begin
            if (all || m_seq[i] > s) k++; else break;
        end
        return k;
    endfunction

    function automatic int rel_count(int c);
        int k = 0;
        if (c == 0) return 0;
        for (int i = 0; i < m_n; i++) begin
            if (m_seq[i] <= c) k++; else break;
        end
        return k;
    endfunction

    // Called at the negedge right after the request edge.
    task automatic expect_undo(string req, int n);
        for (int i = 0; i < n; i++) begin
            int idx = m_n - 1;
            check({req, " restore_valid"}, int'(restore_valid), 1);
            check({req, " restore_arch"}, int'(restore_arch), m_arch[idx]);
            check({req, " restore_phys"}, int'(restore_phys), m_prev[idx]);
            check({req, " free_phys"}, int'(free_phys), m_new[idx]);
            m_n--; exp_u++;
            @(negedge clk);
        end
        check({req, " trailing busy"}, int'(busy), 1);
        check({req, " trailing no restore"}, int'(restore_valid), 0);
        @(negedge clk);
        check({req, " idle after walk"}, int'(busy), 0);
        check("R8 undone_cnt", int'(undone_cnt), exp_u);
    endtask

    task automatic expect_release(string req, int n, bit noise);
        for (int i = 0; i < n; i++) begin
            check({req, " free_valid"}, int'(free_valid), 1);
            check({req, " no restore"}, int'(restore_valid), 0);
            check({req, " free_phys"}, int'(free_phys), m_prev[0]);
            for (int j = 0; j < m_n - 1; j++) begin
                m_seq[j] = m_seq[j+1]; m_arch[j] = m_arch[j+1];
                m_new[j] = m_new[j+1]; m_prev[j] = m_prev[j+1];
            end
            m_n--; exp_c++;
            squash_valid = noise; squash_seq = 0; app_valid = noise;
            @(negedge clk);
        end
        squash_valid = 0; app_valid = 0;
        check({req, " trailing busy"}, int'(busy), 1);
        @(negedge clk);
        check({req, " idle after walk"}, int'(busy), 0);
        check("R8 committed_cnt", int'(committed_cnt), exp_c);
    endtask

    task automatic commit_ignored(string req, int c);
        request(0, 0, 0, c);
        check({req, " busy stays low"}, int'(busy), 0);
        check({req, " nothing freed"}, int'(free_valid), 0);
        @(negedge clk);
        check("R8 committed_cnt unchanged", int'(committed_cnt), exp_c);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; app_valid = 0; squash_valid = 0; flush_valid = 0;
        app_seq = 0; squash_seq = 0; commit_seq = 0;
        app_arch = 0; app_new_phys = 0; app_prev_phys = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 busy", int'(busy), 0);
        check("R1 full", int'(full), 0);
        check("R1 free_valid", int'(free_valid), 0);
        check("R1 restore_valid", int'(restore_valid), 0);
        check("R1 undone_cnt", int'(undone_cnt), 0);
        check("R1 committed_cnt", int'(committed_cnt), 0);
        commit_ignored("R6 empty log", 100);

        // R3 basic squash
        for (int i = 0; i < 6; i++) append(i, 40 + i, i + 1);
        request(1, 15, 0, 0);
        expect_undo("R3 squash S=15", undo_count(15, 0));

        // R6 / R5
        commit_ignored("R6 zero commit", 0);
        commit_ignored("R6 stale commit", 5);
        request(0, 0, 0, 12);
        expect_release("R5 commit C=12", rel_count(12), 0);

        // R3/R5 sweep over squash and commit targets
        for (int t = 0; t < 10; t++) begin
            int base;
            while (m_n < 4) append(t + m_n, 60 + t + m_n, 3 * t + m_n);
            base = m_seq[0];
            request(1, base - 1 + t, 0, 0);
            expect_undo("R3 sweep squash", undo_count(base - 1 + t, 0));
            while (m_n < 4) append(t + 7, 90 - t, t + 20);
            base = m_seq[0];
            if (base - 2 + t < m_seq[0]) commit_ignored("R6 sweep stale", base - 2 + t);
            else begin
                request(0, 0, 0, base - 2 + t);
                expect_release("R5 sweep commit", rel_count(base - 2 + t), 0);
            end
        end

        // R4 flush, R2 full
        request(0, 0, 1, 0);
        expect_undo("R4 flush", undo_count(0, 1));
        for (int i = 0; i < 32; i++) append(i, 64 + i, 127 - i);
        @(negedge clk);
        check("R2 full at 32", int'(full), 1);
        append(3, 5, 6);
        check("R2 full after extra append", int'(full), 1);
        request(0, 0, 1, 0);
        check("R2 youngest kept is 32nd", int'(restore_arch), 31);
        expect_undo("R4 flush full log", undo_count(0, 1));

        // R7 priority
        for (int i = 0; i < 4; i++) append(i + 2, 10 + i, 20 + i);
        request(1, m_seq[1], 0, m_seq[3]);
        expect_undo("R7 squash beats commit", undo_count(m_seq[1], 0));
        check("R7 commit dropped", int'(committed_cnt), exp_c);
        append(9, 11, 12);
        request(1, m_seq[0], 1, 0);
        expect_undo("R7 flush beats squash", undo_count(0, 1));

        // R7 requests and appends during a walk are ignored
        for (int i = 0; i < 4; i++) append(i + 1, 30 + i, 50 + i);
        request(0, 0, 0, m_seq[2]);
        expect_release("R7 commit with noise", rel_count(m_seq[2]), 1);
        request(0, 0, 1, 0);
        check("R7 one record left", undo_count(0, 1), 1);
        expect_undo("R7 flush remainder", undo_count(0, 1));
        @(negedge clk);
        check("R8 final undone_cnt", int'(undone_cnt), exp_u);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule